// File: doc/BRIEF.md
# Audio Clock Ratio and Lock Monitor

This block runs entirely on the system clock. It samples the audio word clock and bit clock, and it counts system-clock cycles between word-clock rising edges to work out whether the system clock runs at 256, 384 or 512 times the sample rate. From the accepted ratio it derives a one-cycle enable that fires at a steady 256 times the sample rate, which the converter filters downstream use as their processing rate.

The block also checks lock. At every word-clock period it compares the measured length against the nominal length for the accepted ratio. The allowed error is a number of bit-clock periods, and the bit-clock period is measured on the fly. When the error is too large, or when the word clock stops, the playback path is told to sit at midscale and the record path to send zeros until lock is regained. After any reset, a fixed start-up count holds both paths quiet. A separate counter watches the serial input data and raises a flag once the data has been zero for a long, programmable number of bit clocks.

Top module: `clkmon_top`

## Requirements
- R1: After `rstN` rises, `initDone` stays 0 for INIT_CYCLES-1 rising clock edges and is 1 from the INIT_CYCLES-th edge onward. While it is 0, `dacMute` and `adcZero` are 1.
- R2: A word period shorter than 320 system clocks is classed as 256fS (`ratioCode` 0). One shorter than 448 is classed as 384fS (code 1). Any longer one is classed as 512fS (code 2). A class is accepted into `ratioCode` and `ratioValid` only when two consecutive measurements agree, so a single differing period leaves `ratioCode` unchanged.
- R3: `tick256` is 0 while `ratioValid` is 0. Once a ratio is accepted, any window of one steady word period holds exactly 256 ticks.
- R4: A word period that differs from the nominal length of the accepted ratio by at most TOL_BITS (5) measured bit-clock periods keeps lock, and `dacMute` stays 0.
- R5: A word period that differs from nominal by more than TOL_BITS bit-clock periods, which includes 6 bit periods, drops lock at the next word-clock edge. `dacMute` and `adcZero` are then 1 before the following word period ends.
- R6: Lock returns only after two consecutive in-tolerance word periods measured with the accepted ratio. One good period is not enough.
- R7: If no word-clock rising edge arrives for TIMEOUT system clocks, lock is dropped.
- R8: With `zeroDetEn` at 1, `zeroFlag` rises once ZERO_LIMIT consecutive bit clocks have sampled `dataIn` as 0. A single bit sampled as 1 clears the run and the flag.
- R9: With `zeroDetEn` at 0, `zeroFlag` is 0, but the run count keeps accumulating. Enabling detection after a long zero run shows the flag at once.
- R10: The zero-run counter saturates at ZERO_LIMIT, so the flag stays set however long the zero run lasts.
- R11: While `rstN` is 0, `dacMute` and `adcZero` are 1, and `ratioValid`, `tick256`, `zeroFlag` and `initDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (external or power-on) |
| wordClk | input | 1 | Audio word (sample-rate) clock |
| bitClk | input | 1 | Audio bit clock |
| dataIn | input | 1 | Serial audio input data, sampled on bit-clock rising edges |
| zeroDetEn | input | 1 | Enables the sustained-zero flag |
| tick256 | output | 1 | One-cycle enable at 256 times the sample rate |
| ratioCode | output | 2 | Accepted ratio: 0 = 256fS, 1 = 384fS, 2 = 512fS |
| ratioValid | output | 1 | A ratio has been accepted |
| initDone | output | 1 | Start-up count after reset has expired |
| dacMute | output | 1 | Force playback output to midscale |
| adcZero | output | 1 | Force record output to zero |
| zeroFlag | output | 1 | Input data has been zero for ZERO_LIMIT bit clocks |

## Verification
Steady frames at each of the three ratios show that classification, two-step acceptance and the tick rate hold at every divide setting. Directed frames that are long or short by exactly five and exactly six bit periods pin down the tolerance edge. Randomly drawn drifts up to seven bit periods, at random ratios, are then compared against a bench function, and the recovery frames that follow separate one good period from two. A stalled word clock exercises the timeout. Zero runs of about one, two and three frames set against a limit of 100 tell apart the threshold, saturation without wrap, clearing by a single set bit, and accumulation while detection is disabled.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2
  } ratio_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   tickEn;
    ratio_e ratio;
  } ctlStrobe_t;

endpackage

// File: rtl/clkmon_datapath.sv
module clkmon_datapath import clkmon_pkg::*; #(
  parameter int TIMEOUT    = 1024,
  parameter int ZERO_LIMIT = 65536,
  parameter int PW         = $clog2(TIMEOUT + 2),
  parameter int ZW         = $clog2(ZERO_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wordClk,
  input  logic          bitClk,
  input  logic          dataIn,
  input  logic          zeroDetEn,
  input  ctlStrobe_t    ctl,
  output logic          measValid,
  output logic          stall,
  output logic [PW-1:0] measPeriod,
  output logic [PW-1:0] bitPeriod,
  output logic          tick,
  output logic          zeroFlag
);

  localparam logic [PW-1:0] TMAX = PW'(TIMEOUT);
  localparam logic [ZW-1:0] ZMAX = ZW'(ZERO_LIMIT);

  logic wcS1, wcS2, bcS1, bcS2, dS1;
  logic wordRise, bitRise;
  logic seenWord, seenBit;
  logic [PW-1:0] periodCnt, bitCnt;
  logic [ZW-1:0] zeroRun;
  logic [1:0]    divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wcS1 <= 1'b0; wcS2 <= 1'b0;
      bcS1 <= 1'b0; bcS2 <= 1'b0;
      dS1  <= 1'b0;
    end else begin
      wcS1 <= wordClk; wcS2 <= wcS1;
      bcS1 <= bitClk;  bcS2 <= bcS1;
      dS1  <= dataIn;
    end
  end

  assign wordRise = wcS1 & ~wcS2;
  assign bitRise  = bcS1 & ~bcS2;

  // word period counter, saturating at TIMEOUT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      seenWord  <= 1'b0;
    end else if (wordRise) begin
      periodCnt <= '0;
      seenWord  <= 1'b1;
    end else if (periodCnt != TMAX) begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  assign measValid  = wordRise & seenWord;
  assign measPeriod = periodCnt + 1'b1;
  assign stall      = seenWord & ~wordRise & (periodCnt == TMAX - 1'b1);

  // bit period measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      bitPeriod <= '0;
      seenBit   <= 1'b0;
    end else if (bitRise) begin
      bitCnt  <= '0;
      seenBit <= 1'b1;
      if (seenBit) bitPeriod <= bitCnt + 1'b1;
    end else if (bitCnt != TMAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // sustained-zero run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= '0;
    end else if (bitRise) begin
      if (dS1)                  zeroRun <= '0;
      else if (zeroRun != ZMAX) zeroRun <= zeroRun + 1'b1;
    end
  end

  assign zeroFlag = zeroDetEn & (zeroRun == ZMAX);

  // 256fS enable divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!ctl.tickEn) begin
      divCnt <= '0;
    end else begin
      case (ctl.ratio)
        RATIO_384: divCnt <= (divCnt >= 2'd2) ? 2'd0 : divCnt + 1'b1;
        RATIO_512: divCnt <= (divCnt == 2'd0) ? 2'd1 : 2'd0;
        default:   divCnt <= 2'd0;
      endcase
    end
  end

  always_comb begin
    tick = 1'b0;
    if (ctl.tickEn) begin
      case (ctl.ratio)
        RATIO_384: tick = (divCnt != 2'd2);
        RATIO_512: tick = (divCnt == 2'd0);
        default:   tick = 1'b1;
      endcase
    end
  end

  assert_zero_sat_R10: assert property (@(posedge clk) disable iff (!rstN)
    zeroRun <= ZMAX);

  assert_period_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= TMAX);

  assert_tick_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tickEn && ctl.ratio == RATIO_512 && $past(ctl.tickEn) &&
     $past(ctl.ratio) == RATIO_512 && $past(tick)) |-> !tick);

endmodule

// File: rtl/clkmon_control.sv
module clkmon_control import clkmon_pkg::*; #(
  parameter int INIT_CYCLES = 1024,
  parameter int TOL_BITS    = 5,
  parameter int PW          = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          measValid,
  input  logic          stall,
  input  logic [PW-1:0] measPeriod,
  input  logic [PW-1:0] bitPeriod,
  output ctlStrobe_t    ctl,
  output logic          ratioValid,
  output ratio_e        ratioCode,
  output logic          initDone,
  output logic          dacMute,
  output logic          adcZero
);

  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [IW-1:0] ILAST = IW'(INIT_CYCLES - 1);
  localparam logic [PW-1:0] LIM_A = PW'((256 + 384) / 2);
  localparam logic [PW-1:0] LIM_B = PW'((384 + 512) / 2);
  localparam logic [PW+3:0] TOLW  = (PW + 4)'(TOL_BITS);

  logic [IW-1:0] initCnt;
  ratio_e        measClass, candClass;
  logic          candValid, goodSeen, inSync, inTol;
  logic [PW-1:0] nominal, drift;
  logic [PW+3:0] tolLim;

  function automatic ratio_e classify(input logic [PW-1:0] p);
    if (p < LIM_A)      return RATIO_256;
    else if (p < LIM_B) return RATIO_384;
    else                return RATIO_512;
  endfunction

  always_comb begin
    measClass = classify(measPeriod);
    case (measClass)
      RATIO_384: nominal = PW'(384);
      RATIO_512: nominal = PW'(512);
      default:   nominal = PW'(256);
    endcase
    drift  = (measPeriod >= nominal) ? measPeriod - nominal : nominal - measPeriod;
    tolLim = TOLW * {4'b0000, bitPeriod};
    inTol  = ratioValid && (ratioCode == measClass) && ({4'b0000, drift} <= tolLim);
  end

  // start-up count after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt  <= '0;
      initDone <= 1'b0;
    end else if (!initDone) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == ILAST) initDone <= 1'b1;
    end
  end

  // ratio acceptance and lock tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candValid  <= 1'b0;
      candClass  <= RATIO_256;
      ratioValid <= 1'b0;
      ratioCode  <= RATIO_256;
      goodSeen   <= 1'b0;
      inSync     <= 1'b0;
    end else if (measValid) begin
      candClass <= measClass;
      candValid <= 1'b1;
      if (candValid && candClass == measClass) begin
        ratioCode  <= measClass;
        ratioValid <= 1'b1;
      end
      if (inTol) begin
        if (goodSeen) inSync <= 1'b1;
        goodSeen <= 1'b1;
      end else begin
        inSync   <= 1'b0;
        goodSeen <= 1'b0;
      end
    end else if (stall) begin
      inSync   <= 1'b0;
      goodSeen <= 1'b0;
    end
  end

  assign ctl.tickEn = ratioValid;
  assign ctl.ratio  = ratioCode;
  assign dacMute    = ~(initDone & inSync);
  assign adcZero    = ~(initDone & inSync);

  assert_init_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_lock_on_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> $past(measValid));

  assert_lock_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inSync) |-> ($past(measValid) || $past(stall)));

  assert_ratio_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ratioValid && $past(ratioValid) && ratioCode != $past(ratioCode)) |-> $past(measValid));

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top import clkmon_pkg::*; #(
  parameter int INIT_CYCLES = 1024,
  parameter int TIMEOUT     = 1024,
  parameter int TOL_BITS    = 5,
  parameter int ZERO_LIMIT  = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordClk,
  input  logic       bitClk,
  input  logic       dataIn,
  input  logic       zeroDetEn,
  output logic       tick256,
  output logic [1:0] ratioCode,
  output logic       ratioValid,
  output logic       initDone,
  output logic       dacMute,
  output logic       adcZero,
  output logic       zeroFlag
);

  localparam int PW = $clog2(TIMEOUT + 2);
  localparam int ZW = $clog2(ZERO_LIMIT + 1);

  ctlStrobe_t    ctl;
  ratio_e        ratioSel;
  logic          measValid, stall;
  logic [PW-1:0] measPeriod, bitPeriod;

  clkmon_datapath #(
    .TIMEOUT(TIMEOUT), .ZERO_LIMIT(ZERO_LIMIT), .PW(PW), .ZW(ZW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .bitClk(bitClk),
    .dataIn(dataIn), .zeroDetEn(zeroDetEn), .ctl(ctl),
    .measValid(measValid), .stall(stall), .measPeriod(measPeriod),
    .bitPeriod(bitPeriod), .tick(tick256), .zeroFlag(zeroFlag)
  );

  clkmon_control #(
    .INIT_CYCLES(INIT_CYCLES), .TOL_BITS(TOL_BITS), .PW(PW)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .measValid(measValid), .stall(stall),
    .measPeriod(measPeriod), .bitPeriod(bitPeriod), .ctl(ctl),
    .ratioValid(ratioValid), .ratioCode(ratioSel), .initDone(initDone),
    .dacMute(dacMute), .adcZero(adcZero)
  );

  assign ratioCode = ratioSel;

endmodule

// File: tb/clkmon_top_bench.sv
module clkmon_top_bench;

  localparam int ZL = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordClk = 1'b0, bitClk = 1'b0, dataIn = 1'b0, zeroDetEn = 1'b0;
  logic tick256, ratioValid, initDone, dacMute, adcZero, zeroFlag;
  logic [1:0] ratioCode;

  int checks = 0;
  int fails = 0;
  int tickSeen = 0;

  always #10 clk = ~clk;

  clkmon_top #(.ZERO_LIMIT(ZL)) u_clkmon_top (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .bitClk(bitClk),
    .dataIn(dataIn), .zeroDetEn(zeroDetEn), .tick256(tick256),
    .ratioCode(ratioCode), .ratioValid(ratioValid), .initDone(initDone),
    .dacMute(dacMute), .adcZero(adcZero), .zeroFlag(zeroFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 pattern, 1 all zero, 2 all one
  task automatic frame(input int len, input int bp, input int mode);
    tickSeen = 0;
    for (int i = 0; i < len; i++) begin
      wordClk = (i < bp * 32);
      bitClk  = ((i % bp) >= bp / 2);
      dataIn  = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : (((i / bp) % 3) == 0);
      @(negedge clk);
      tickSeen += int'(tick256);
    end
  endtask

  task automatic stallWord(input int n, input int bp);
    for (int i = 0; i < n; i++) begin
      wordClk = 1'b0;
      bitClk  = ((i % bp) >= bp / 2);
      @(negedge clk);
    end
  endtask

  function automatic int expectLost(input int d, input int bp);
    return ((d < 0 ? -d : d) > 5 * bp) ? 1 : 0;
  endfunction

  function automatic int bpOf(input int code);
    return (code == 0) ? 4 : (code == 1) ? 6 : 8;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    finishRun();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1c0d);
    @(negedge clk);
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 dacMute", int'(dacMute), 1);
    check("R11 adcZero", int'(adcZero), 1);
    check("R11 ratioValid", int'(ratioValid), 0);
    check("R11 tick256", int'(tick256), 0);
    check("R11 zeroFlag", int'(zeroFlag), 0);
    check("R11 initDone", int'(initDone), 0);

    rstN = 1'b1;
    fork
      begin repeat (6) frame(256, 4, 0); end
      begin
        repeat (1023) @(negedge clk);
        check("R1 initDone before count", int'(initDone), 0);
        check("R1 dacMute during init", int'(dacMute), 1);
        @(negedge clk);
        check("R1 initDone at count", int'(initDone), 1);
      end
    join
    check("R2 ratio 256", int'(ratioCode), 0);
    check("R2 ratioValid", int'(ratioValid), 1);
    check("R6 locked after start", int'(dacMute), 0);
    frame(256, 4, 0);
    check("R3 ticks at 256fS", tickSeen, 256);

    // tolerance edge
    frame(256 + 20, 4, 0); frame(256, 4, 0);
    check("R4 +5 bits keeps lock", int'(dacMute), 0);
    frame(256 - 20, 4, 0); frame(256, 4, 0);
    check("R4 -5 bits keeps lock", int'(dacMute), 0);
    frame(256 + 24, 4, 0); frame(256, 4, 0);
    check("R5 +6 bits dacMute", int'(dacMute), 1);
    check("R5 +6 bits adcZero", int'(adcZero), 1);
    frame(256, 4, 0);
    check("R6 one good period not enough", int'(dacMute), 1);
    frame(256, 4, 0);
    check("R6 two good periods relock", int'(dacMute), 0);
    frame(256 - 24, 4, 0); frame(256, 4, 0);
    check("R5 -6 bits dacMute", int'(dacMute), 1);
    repeat (2) frame(256, 4, 0);

    // 384fS
    repeat (2) frame(384, 6, 0);
    check("R2 single differing period ignored", int'(ratioCode), 0);
    check("R5 ratio change drops lock", int'(dacMute), 1);
    repeat (4) frame(384, 6, 0);
    check("R2 ratio 384", int'(ratioCode), 1);
    check("R6 locked at 384", int'(dacMute), 0);
    frame(384, 6, 0);
    check("R3 ticks at 384fS", tickSeen, 256);

    // 512fS
    repeat (6) frame(512, 8, 0);
    check("R2 ratio 512", int'(ratioCode), 2);
    frame(512, 8, 0);
    check("R3 ticks at 512fS", tickSeen, 256);

    // random drifts
    for (int k = 0; k < 8; k++) begin
      int code, bp, nom, d;
      code = int'($urandom_range(0, 2));
      bp = bpOf(code);
      nom = bp * 64;
      repeat (6) frame(nom, bp, 0);
      check("R6 random relock", int'(dacMute), 0);
      check("R2 random ratio", int'(ratioCode), code);
      d = (int'($urandom_range(0, 14)) - 7) * bp;
      frame(nom + d, bp, 0); frame(nom, bp, 0);
      check("R4 R5 random drift", int'(dacMute), expectLost(d, bp));
      repeat (2) frame(nom, bp, 0);
      check("R6 random recovery", int'(dacMute), 0);
    end

    // stall
    repeat (6) frame(256, 4, 0);
    stallWord(1100, 4);
    check("R7 stalled word clock", int'(dacMute), 1);
    repeat (6) frame(256, 4, 0);
    check("R7 recovery after stall", int'(dacMute), 0);

    // zero detection
    zeroDetEn = 1'b1;
    frame(256, 4, 2);
    frame(256, 4, 1);
    check("R8 below limit", int'(zeroFlag), 0);
    frame(256, 4, 1);
    check("R8 at limit", int'(zeroFlag), 1);
    repeat (2) frame(256, 4, 1);
    check("R10 saturates no wrap", int'(zeroFlag), 1);
    frame(256, 4, 2);
    check("R8 cleared by a one", int'(zeroFlag), 0);
    zeroDetEn = 1'b0;
    repeat (3) frame(256, 4, 1);
    check("R9 disabled flag low", int'(zeroFlag), 0);
    zeroDetEn = 1'b1;
    #1;
    check("R9 run kept while disabled", int'(zeroFlag), 1);

    finishRun();
  end

endmodule